// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Updates

This block is a 16-pin general-purpose I/O port for a simple register bus. Each pin has a direction bit that drives an output enable. Software can change the output value in four ways. It can load the whole word at once. It can also write a mask of ones to drive the selected pins high, to drive them low, or to invert them. Pins whose mask bit is zero keep their value, so any group of pins changes in a single access and no read-modify-write is needed.

The pin inputs pass through a two-stage synchronizer. The synchronized levels feed a read-only status register and the interrupt logic. A pin takes part in the interrupt only when its mask bit is set. The mask is changed through two addresses: ones written to the first address enable pins, and ones written to the second address disable them. The interrupt output is level-sensitive. It stays high while any enabled pin reads high.

Register writes take effect on the clock edge where `wr_en_i` is high. Reads are combinational from `addr_i`. The address map is:

| Address | Write effect | Read value |
|---|---|---|
| 0 | load output word | output word |
| 1 | drive pins high where written bit is 1 | output word |
| 2 | drive pins low where written bit is 1 | output word |
| 3 | invert pins where written bit is 1 | output word |
| 4 | load direction (1 = output) | direction |
| 5 | none | synchronized pin levels |
| 6 | enable mask bits where written bit is 1 | interrupt mask |
| 7 | disable mask bits where written bit is 1 | interrupt mask |
| 8–15 | none | zero |

Top module: `gpio_port`

## Requirements
- R1: After reset, with `wr_en_i` low and pins held low: `pin_o`, `pin_oe_o`, the interrupt mask and `irq_o` are all zero, and every address reads zero.
- R2: A write to address 0 loads `wdata_i` into the output word. `pin_o` shows the new word from the next clock edge.
- R3: A write to address 1 sets the output bits where `wdata_i` is 1 and leaves the other bits unchanged.
- R4: A write to address 2 clears the output bits where `wdata_i` is 1 and leaves the other bits unchanged.
- R5: A write to address 3 inverts the output bits where `wdata_i` is 1 and leaves the other bits unchanged.
- R6: A write to address 4 loads the direction word. The direction word drives `pin_oe_o` (1 = output) and reads back at address 4.
- R7: Address 5 reads the level that `pin_i` had two clock edges earlier. Each pin goes through its own two-flop synchronizer.
- R8: A write to address 6 sets mask bits where `wdata_i` is 1. A write to address 7 clears mask bits where `wdata_i` is 1. Both addresses read back the current mask.
- R9: `irq_o` is high exactly when at least one pin has its mask bit set and its synchronized level high. Unmasked pins have no effect on it.
- R10: Addresses 0 to 3 all read the output word. Writes to address 5 or to addresses 8 to 15 change no state, and those unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| pin_i | input | 16 | Sensed pin levels, asynchronous |
| pin_o | output | 16 | Output word |
| pin_oe_o | output | 16 | Per-pin output enable (direction) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench checks the atomic writes for both ways they can fail. A set, clear or toggle that touched pins outside its mask, or that acted like a plain load, would corrupt bits that the bench expects to stay as they were. These writes are driven with random masks over random starting words. The bench also drives a new pin pattern on every cycle and compares the status read against the pattern from exactly two cycles earlier. A synchronizer with one stage or three stages fails this comparison on the first cycle where the pattern changes. Writes to the status address and to unmapped addresses are mixed into the random traffic. A decoder that aliased any of them onto a real register would show up as an unexpected change in the outputs or in a readback. The interrupt is checked against the mask and the pins together. An inverted mask, or an interrupt that ignored the mask, would raise `irq_o` in cases where the bench expects it low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 4'd0,
    A_SET  = 4'd1,
    A_CLR  = 4'd2,
    A_TGL  = 4'd3,
    A_DIR  = 4'd4,
    A_STAT = 4'd5,
    A_MSET = 4'd6,
    A_MCLR = 4'd7
  } reg_addr_e;

  typedef struct packed {
    logic data;
    logic set;
    logic clr;
    logic tgl;
    logic dir;
    logic mset;
    logic mclr;
  } wr_dec_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic         tgl_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    unique case (1'b1)
      ld_i:    q_d = wdata_i;
      set_i:   q_d = q_o | wdata_i;
      clr_i:   q_d = q_o & ~wdata_i;
      tgl_i:   q_d = q_o ^ wdata_i;
      default: q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | wdata_i;
    else if (clr_i) q_o <= q_o & ~wdata_i;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  wr_dec_t             wr;
  logic [NUM_PINS-1:0] out_q, dir_q, mask_q, sync_q;

  // write decode: one strobe per register
  always_comb begin
    wr = '0;
    if (wr_en_i) begin
      unique case (addr_i)
        A_DATA:  wr.data = 1'b1;
        A_SET:   wr.set  = 1'b1;
        A_CLR:   wr.clr  = 1'b1;
        A_TGL:   wr.tgl  = 1'b1;
        A_DIR:   wr.dir  = 1'b1;
        A_MSET:  wr.mset = 1'b1;
        A_MCLR:  wr.mclr = 1'b1;
        default: wr = '0;
      endcase
    end
  end

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_q)
  );

  gpio_out_reg #(.W(NUM_PINS)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (wr.data),
    .set_i   (wr.set),
    .clr_i   (wr.clr),
    .tgl_i   (wr.tgl),
    .wdata_i (wdata_i),
    .q_o     (out_q)
  );

  gpio_mask_reg #(.W(NUM_PINS)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wr.mset),
    .clr_i   (wr.mclr),
    .wdata_i (wdata_i),
    .q_o     (mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     dir_q <= '0;
    else if (wr.dir) dir_q <= wdata_i;

  always_comb begin
    unique case (addr_i)
      A_DATA, A_SET, A_CLR, A_TGL: rdata_o = out_q;
      A_DIR:                       rdata_o = dir_q;
      A_STAT:                      rdata_o = sync_q;
      A_MSET, A_MCLR:              rdata_o = mask_q;
      default:                     rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(mask_q & sync_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [3:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] pin_i,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] pin_oe_o,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] sync_q,
  input logic         irq_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;

  // R2
  load_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd0) |=> pin_o == $past(wdata_i));
  // R3
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd1) |=> pin_o == ($past(pin_o) | $past(wdata_i)));
  // R4
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd2) |=> pin_o == ($past(pin_o) & ~$past(wdata_i)));
  // R5
  tgl_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd3) |=> pin_o == ($past(pin_o) ^ $past(wdata_i)));
  // R6
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 4'd4) |=> $stable(pin_oe_o));
  // R7
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> sync_q == $past(pin_i, 2));
  // R8
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd6) |=> (mask_q & $past(wdata_i)) == $past(wdata_i));
  // R8
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd7) |=> (mask_q & $past(wdata_i)) == '0);
  // R9
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
  // R10
  dead_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == 4'd5 || addr_i[3])) |=> $stable(pin_o) && $stable(mask_q));
endmodule

bind gpio_port gpio_port_chk #(.W(NUM_PINS)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pin_i    (pin_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .mask_q   (mask_q),
  .sync_q   (sync_q),
  .irq_o    (irq_o)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   addr = 4'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [W-1:0] m_out = '0, m_dir = '0, m_mask = '0;
  logic [31:0]  rng = 32'h1234_5678;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic [W-1:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      4'd0: m_out  = d;
      4'd1: m_out  = m_out | d;
      4'd2: m_out  = m_out & ~d;
      4'd3: m_out  = m_out ^ d;
      4'd4: m_dir  = d;
      4'd6: m_mask = m_mask | d;
      4'd7: m_mask = m_mask & ~d;
      default: ;
    endcase
  endtask

  task automatic check_all(string req);
    check(req, pin_out, m_out);
    check(req, pin_oe, m_dir);
    check(req, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(m_mask & pin_in)});
    for (int a = 0; a < 16; a++) begin
      case (a)
        0, 1, 2, 3: rd_check(req, 4'(a), m_out);
        4:          rd_check(req, 4'(a), m_dir);
        5:          rd_check(req, 4'(a), pin_in);
        6, 7:       rd_check(req, 4'(a), m_mask);
        default:    rd_check(req, 4'(a), '0);
      endcase
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", pin_out, '0);
    check("R1", pin_oe, '0);
    check("R1", {15'd0, irq}, '0);
    for (int a = 0; a < 16; a++) rd_check("R1", 4'(a), '0);

    // walking bits through each update mode
    for (int b = 0; b < W; b++) begin
      wr(4'd0, 16'hA5C3);                 check("R2", pin_out, m_out);
      wr(4'd1, 16'(1) << b);              check("R3", pin_out, m_out);
      wr(4'd2, 16'(1) << ((b + 5) % W));  check("R4", pin_out, m_out);
      wr(4'd3, 16'(3) << b);              check("R5", pin_out, m_out);
      wr(4'd4, ~(16'(1) << b));           check("R6", pin_oe, m_dir);
    end
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'hFFFF); check("R5", pin_out, 16'hFFFF);
    wr(4'd2, 16'h00FF); check("R4", pin_out, 16'hFF00);
    wr(4'd1, 16'h0000); check("R3", pin_out, 16'hFF00);

    // random traffic, static pins, including dead addresses
    @(negedge clk);
    pin_in = 16'h5A0F;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      rng = next_rng(rng);
      wr(rng[3:0], rng[31:16]);
      case (rng[3:0])
        4'd0:       check_all("R2");
        4'd1:       check_all("R3");
        4'd2:       check_all("R4");
        4'd3:       check_all("R5");
        4'd4:       check_all("R6");
        4'd6, 4'd7: check_all("R8");
        default:    check_all("R10");
      endcase
    end

    // interrupt against mask and pin pattern
    wr(4'd7, 16'hFFFF);
    for (int p = 0; p < W; p++) begin
      @(negedge clk);
      pin_in = 16'(1) << p;
      repeat (2) @(negedge clk);
      check("R9", {15'd0, irq}, '0);
      wr(4'd6, 16'(1) << p);
      check("R9", {15'd0, irq}, 16'd1);
      wr(4'd7, 16'(1) << p);
      check("R9", {15'd0, irq}, '0);
    end

    // per-cycle pin sweep: status lags two edges
    begin
      logic [W-1:0] d1, d2, nv;
      wr(4'd6, 16'h0F0F);
      addr = 4'd5;
      d1 = pin_in; d2 = pin_in;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        #1;
        check("R7", rdata, d2);
        check("R9", {15'd0, irq}, {15'd0, |(d2 & m_mask)});
        rng = next_rng(rng);
        nv = rng[W-1:0];
        pin_in = nv;
        d2 = d1;
        d1 = nv;
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule